// File: doc/BRIEF.md
# Burst-Framed SPI Master

This block is an SPI master with a small word-addressed register port. Software puts outgoing bytes into a transmit FIFO and sets two counts. The total count gives the number of bytes clocked in one chip-select frame. The transmit count gives how many of those bytes are taken from the FIFO. A single start bit then launches the whole frame. A typical use is a memory read: a command header followed by read-back data, all in one frame.

Once the transmit-counted bytes are used up, the master sends zero bytes until the total is reached. Every byte shifted in goes into a receive FIFO, including the bytes captured while the header was going out. Software therefore throws away the first transmit-count bytes it reads back. The serial clock comes from the module clock through a divide-by-4 (the default) or divide-by-2 setting. A self-clearing soft reset returns the whole block to its reset state.

Register map (word index on `busAddr`):
- 0 control: bit 0 enable, bit 1 master mode, bit 2 fast clock, bit 8 transmit clear, bit 9 receive clear, bit 10 exchange, bit 31 soft reset.
- 1 total byte count.
- 2 transmit byte count.
- 3 status: bits 6:0 receive level, bits 14:8 transmit level, bit 16 overflow.
- 4 transmit data: a write pushes the low byte.
- 5 receive data: a read pops one byte.

Top module: `spi_burst_master`

## Requirements
- R1: After reset, control, both counts and status read 0, `spiCsN` is 1 and `spiSclk` is 0.
- R2: Writing control with bit 10, bit 0 and bit 1 all set, while idle and with a nonzero total count, starts a frame. Control bit 10 reads 1 while the frame runs and 0 afterwards. With bit 0 clear, the write starts nothing: chip select stays high and bit 10 reads 0.
- R3: A frame shifts exactly total-count bytes (8 × total SCLK rising edges) with `spiCsN` low throughout.
- R4: Byte k of a frame goes out on `spiMosi` as the next transmit-FIFO byte when k is below the transmit count, and as 0x00 otherwise.
- R5: Every byte shifted in during a frame enters the receive FIFO, including the bytes shifted in while FIFO data goes out. The receive level reads in status bits 6:0.
- R6: Transfers use SPI mode 0, MSB first: SCLK idles low, MISO is sampled on the rising edge, and MOSI changes on the falling edge.
- R7: `spiCsN` falls two half SCLK periods before the first SCLK edge and rises one half period after the last edge.
- R8: With control bit 2 at 0, one half SCLK period is 2 module clocks (divide by 4). With bit 2 at 1, it is 1 module clock (divide by 2).
- R9: A write to the transmit data register while the FIFO holds 64 bytes is ignored and sets the sticky overflow flag (status bit 16). The transmit level reads in status bits 14:8. Reading an empty receive FIFO returns 0.
- R10: Writing control bit 8 empties the transmit FIFO and clears the overflow flag. Writing bit 9 empties the receive FIFO.
- R11: Writing control bit 31 sets a soft reset that reads back as 1 for one cycle and then clears itself, leaving every register and FIFO as after R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe (pops the receive FIFO at index 5) |
| busAddr | input | 3 | Register word index |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from `busAddr` |
| spiSclk | output | 1 | Serial clock |
| spiMosi | output | 1 | Serial data out |
| spiMiso | input | 1 | Serial data in |
| spiCsN | output | 1 | Active-low chip select |

## Verification
The bench builds the block with its default 64-byte FIFOs and 16-bit counts. With these values, a 65th push reaches the overflow path, and frames of up to ten bytes cover both the header-then-zeros ordering and the edge of the transmit count, including a count of zero. Frames run under both clock settings. The chip-select and SCLK waveform is compared on every clock against a behavioural timing model. A bench slave returns a byte pattern that depends on a seed, so the MSB-first order and the junk header bytes can be confirmed in the receive FIFO.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  localparam logic [2:0] REG_CTRL   = 3'd0;
  localparam logic [2:0] REG_TOTAL  = 3'd1;
  localparam logic [2:0] REG_TXCNT  = 3'd2;
  localparam logic [2:0] REG_STATUS = 3'd3;
  localparam logic [2:0] REG_TXDATA = 3'd4;
  localparam logic [2:0] REG_RXDATA = 3'd5;

  localparam int CB_EN    = 0;
  localparam int CB_MST   = 1;
  localparam int CB_FAST  = 2;
  localparam int CB_TXCLR = 8;
  localparam int CB_RXCLR = 9;
  localparam int CB_XCH   = 10;
  localparam int CB_SRST  = 31;
  localparam int SB_OVF   = 16;

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_SHIFT, ST_HOLD} seqState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic txPush;
    logic rxPop;
    logic txClr;
    logic rxClr;
    logic load;
    logic fromFifo;
    logic sample;
    logic shift;
    logic rxPush;
    logic sclkToggle;
    logic sclkIdle;
    logic csAssert;
    logic csRelease;
  } dpStrobes_t;
endpackage

// File: rtl/spi_burst_fifo.sv
module spi_burst_fifo #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] popData,
  output logic [LW-1:0]    level,
  output logic             full
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic doPush, doPop, empty;

  assign empty   = (level == '0);
  assign full    = (level == LW'(DEPTH));
  assign doPush  = push && !full;
  assign doPop   = pop && !empty;
  assign popData = empty ? '0 : mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush && !clr) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else if (clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      level <= level + LW'(doPush) - LW'(doPop);
    end
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (full && push && !pop && !clr) |=> (full && level == $past(level)));

  // R5
  level_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    level <= LW'(DEPTH));
endmodule

// File: rtl/spi_burst_dp.sv
module spi_burst_dp
  import spi_burst_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobes_t st,
  input  logic [7:0] wrByte,
  input  logic       misoIn,
  output logic       spiSclk,
  output logic       spiMosi,
  output logic       spiCsN,
  output logic [7:0] rxByte,
  output logic [LW-1:0] rxLevel,
  output logic [LW-1:0] txLevel,
  output logic       txFull
);
  logic [7:0] txHead, txShift, rxShift;
  logic       rxFull;

  spi_burst_fifo #(.DEPTH(DEPTH), .WIDTH(8)) txFifo_i (
    .clk(clk), .rstN(rstN), .clr(st.txClr), .push(st.txPush), .pushData(wrByte),
    .pop(st.load && st.fromFifo), .popData(txHead), .level(txLevel), .full(txFull));

  spi_burst_fifo #(.DEPTH(DEPTH), .WIDTH(8)) rxFifo_i (
    .clk(clk), .rstN(rstN), .clr(st.rxClr), .push(st.rxPush), .pushData(rxShift),
    .pop(st.rxPop), .popData(rxByte), .level(rxLevel), .full(rxFull));

  assign spiMosi = txShift[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      spiSclk <= 1'b0;
      spiCsN  <= 1'b1;
    end else begin
      if (st.load)        txShift <= st.fromFifo ? txHead : 8'h00;
      else if (st.shift)  txShift <= {txShift[6:0], 1'b0};
      if (st.sample)      rxShift <= {rxShift[6:0], misoIn};
      if (st.sclkIdle)        spiSclk <= 1'b0;
      else if (st.sclkToggle) spiSclk <= ~spiSclk;
      if (st.csRelease)     spiCsN <= 1'b1;
      else if (st.csAssert) spiCsN <= 1'b0;
    end
  end

  // R7
  sclk_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    spiSclk |-> !spiCsN);

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.sample, st.shift, st.load}));

  // R5
  rx_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.rxPush && !rxFull && !st.rxPop && !st.rxClr) |=> (rxLevel == $past(rxLevel) + 1'b1));
endmodule

// File: rtl/spi_burst_ctrl.sv
module spi_burst_ctrl
  import spi_burst_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int LW = 7,
  parameter int SLOW_HALF = 2,
  parameter int FAST_HALF = 1,
  localparam int DW = $clog2(SLOW_HALF + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busWr,
  input  logic          busRd,
  input  logic [2:0]    busAddr,
  input  logic [31:0]   busWdata,
  output logic [31:0]   busRdata,
  input  logic [7:0]    rxByte,
  input  logic [LW-1:0] rxLevel,
  input  logic [LW-1:0] txLevel,
  input  logic          txFull,
  output dpStrobes_t    st
);
  seqState_t state;
  logic enQ, mstQ, fastQ, ovfQ, srstQ;
  logic [CNT_W-1:0] totalQ, txCntQ, bytesDone;
  logic [DW-1:0] divCnt, halfLen;
  logic [3:0] edgeCnt;
  logic [CNT_W:0] nextIdx;
  logic wrCtrl, idle, start, tick, lastByte, byteEnd;

  assign idle     = (state == ST_IDLE);
  assign wrCtrl   = busWr && busAddr == REG_CTRL && !srstQ;
  assign start    = wrCtrl && idle && busWdata[CB_XCH] && busWdata[CB_EN] &&
                    busWdata[CB_MST] && !busWdata[CB_SRST] && totalQ != '0;
  assign halfLen  = fastQ ? DW'(FAST_HALF) : DW'(SLOW_HALF);
  assign tick     = !idle && divCnt == halfLen - 1'b1;
  assign nextIdx  = {1'b0, bytesDone} + 1'b1;
  assign lastByte = (nextIdx == {1'b0, totalQ});
  assign byteEnd  = state == ST_SHIFT && tick && edgeCnt == 4'd15;

  always_comb begin
    st            = '0;
    st.txPush     = busWr && busAddr == REG_TXDATA && !srstQ;
    st.rxPop      = busRd && busAddr == REG_RXDATA && !srstQ;
    st.txClr      = srstQ || (wrCtrl && busWdata[CB_TXCLR]);
    st.rxClr      = srstQ || (wrCtrl && busWdata[CB_RXCLR]);
    st.load       = start || (byteEnd && !lastByte);
    st.fromFifo   = start ? (txCntQ != '0) : (nextIdx < {1'b0, txCntQ});
    st.sclkToggle = state == ST_SHIFT && tick;
    st.sample     = st.sclkToggle && !edgeCnt[0];
    st.shift      = st.sclkToggle && edgeCnt[0] && edgeCnt != 4'd15;
    st.rxPush     = byteEnd;
    st.sclkIdle   = srstQ;
    st.csAssert   = start;
    st.csRelease  = srstQ || (state == ST_HOLD && tick);
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      REG_CTRL: begin
        busRdata[CB_EN]   = enQ;
        busRdata[CB_MST]  = mstQ;
        busRdata[CB_FAST] = fastQ;
        busRdata[CB_XCH]  = !idle;
        busRdata[CB_SRST] = srstQ;
      end
      REG_TOTAL:  busRdata[CNT_W-1:0] = totalQ;
      REG_TXCNT:  busRdata[CNT_W-1:0] = txCntQ;
      REG_STATUS: begin
        busRdata[LW-1:0]   = rxLevel;
        busRdata[8 +: LW]  = txLevel;
        busRdata[SB_OVF]   = ovfQ;
      end
      REG_RXDATA: busRdata[7:0] = rxByte;
      default:    busRdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE; enQ <= 1'b0; mstQ <= 1'b0; fastQ <= 1'b0; ovfQ <= 1'b0;
      srstQ <= 1'b0; totalQ <= '0; txCntQ <= '0; bytesDone <= '0;
      divCnt <= '0; edgeCnt <= '0;
    end else if (srstQ) begin
      state <= ST_IDLE; enQ <= 1'b0; mstQ <= 1'b0; fastQ <= 1'b0; ovfQ <= 1'b0;
      srstQ <= 1'b0; totalQ <= '0; txCntQ <= '0; bytesDone <= '0;
      divCnt <= '0; edgeCnt <= '0;
    end else begin
      if (wrCtrl && busWdata[CB_SRST]) srstQ <= 1'b1;
      if (wrCtrl && idle) begin
        enQ   <= busWdata[CB_EN];
        mstQ  <= busWdata[CB_MST];
        fastQ <= busWdata[CB_FAST];
      end
      if (busWr && idle && busAddr == REG_TOTAL) totalQ <= busWdata[CNT_W-1:0];
      if (busWr && idle && busAddr == REG_TXCNT) txCntQ <= busWdata[CNT_W-1:0];
      if (st.txClr) ovfQ <= 1'b0;
      else if (st.txPush && txFull) ovfQ <= 1'b1;

      if (idle) begin
        divCnt <= '0;
        if (start) begin
          state <= ST_SETUP; bytesDone <= '0; edgeCnt <= '0;
        end
      end else begin
        divCnt <= tick ? '0 : divCnt + 1'b1;
        if (tick) begin
          case (state)
            ST_SETUP: begin state <= ST_SHIFT; edgeCnt <= '0; end
            ST_SHIFT: begin
              edgeCnt <= edgeCnt + 1'b1;
              if (edgeCnt == 4'd15) begin
                if (lastByte) state <= ST_HOLD;
                else bytesDone <= nextIdx[CNT_W-1:0];
              end
            end
            default: state <= ST_IDLE;
          endcase
        end
      end
    end
  end

  // R11
  srst_selfclear_chk: assert property (@(posedge clk) disable iff (!rstN)
    srstQ |=> !srstQ);

  // R3
  burst_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    !idle |-> (bytesDone < totalQ));

  // R2
  start_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (idle && !start) |=> idle);
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
  import spi_burst_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = 16,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWr,
  input  logic        busRd,
  input  logic [2:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        spiSclk,
  output logic        spiMosi,
  input  logic        spiMiso,
  output logic        spiCsN
);
  dpStrobes_t st;
  logic [7:0] rxByte;
  logic [LW-1:0] rxLevel, txLevel;
  logic txFull;

  spi_burst_ctrl #(.CNT_W(CNT_W), .LW(LW)) ctrl_i (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .rxByte(rxByte), .rxLevel(rxLevel),
    .txLevel(txLevel), .txFull(txFull), .st(st));

  spi_burst_dp #(.DEPTH(DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .st(st), .wrByte(busWdata[7:0]), .misoIn(spiMiso),
    .spiSclk(spiSclk), .spiMosi(spiMosi), .spiCsN(spiCsN), .rxByte(rxByte),
    .rxLevel(rxLevel), .txLevel(txLevel), .txFull(txFull));
endmodule

// File: tb/spi_burst_master_tb_top.sv
module spi_burst_master_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWr = 1'b0, busRd = 1'b0;
  logic [2:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic spiSclk, spiMosi, spiMiso, spiCsN;

  always #5 clk = ~clk;

  spi_burst_master dut_i (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .spiSclk(spiSclk), .spiMosi(spiMosi),
    .spiMiso(spiMiso), .spiCsN(spiCsN));

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc++;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural pin-timing model (R3, R7, R8)
  bit mActive = 0;
  int mStart = 0, mHalf = 2, mN = 0;
  always @(negedge clk) begin
    int n, e;
    bit expCs, expSclk;
    if (rstN && !done) begin
      expCs = 1; expSclk = 0;
      if (mActive) begin
        n = cyc - mStart;
        if (n >= 0 && n < mHalf * (16 * mN + 2)) expCs = 0;
        if (n >= 0) begin
          e = n / mHalf - 1;
          if (e < 0) e = 0;
          if (e > 16 * mN) e = 16 * mN;
          expSclk = e[0];
        end
      end
      chk(spiCsN == !expCs ? 1'b0 : 1'b1, "R7", "csN per clock", spiCsN, !expCs);
      chk(spiSclk == expSclk, "R8", "sclk per clock", spiSclk, expSclk);
    end
  end

  // slave: captures MOSI and advances MISO on each rising SCLK while selected
  int bitCnt = 0, base = 0;
  bit mosiBits[$];
  logic [7:0] seed = 8'h00;
  function automatic logic [7:0] pat(logic [7:0] s, int k);
    return s ^ 8'(k * 29 + 7);
  endfunction
  function automatic logic patBit(logic [7:0] s, int rel);
    logic [7:0] b;
    b = pat(s, rel / 8);
    return b[7 - (rel % 8)];
  endfunction
  always @(posedge spiSclk) if (!spiCsN) begin
    mosiBits.push_back(spiMosi);
    bitCnt++;
  end
  assign spiMiso = patBit(seed, bitCnt - base);

  task automatic busWrite(logic [2:0] a, logic [31:0] d);
    @(negedge clk); busWr = 1; busAddr = a; busWdata = d;
    @(posedge clk); #1 busWr = 0;
  endtask

  task automatic busRead(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); busRd = 1; busAddr = a;
    #1 d = busRdata;
    @(posedge clk); #1 busRd = 0;
  endtask

  task automatic runBurst(int n, byte unsigned tx[$], bit fast, logic [7:0] sd);
    logic [31:0] r;
    int h;
    h = fast ? 1 : 2;
    seed = sd;
    foreach (tx[i]) busWrite(3'd4, {24'h0, tx[i]});
    busWrite(3'd1, n);
    busWrite(3'd2, tx.size());
    base = bitCnt;
    @(negedge clk);
    mStart = cyc + 1; mHalf = h; mN = n; mActive = 1;
    busWr = 1; busAddr = 3'd0; busWdata = 32'h403 | (32'(fast) << 2);
    @(posedge clk); #1 busWr = 0;
    repeat (h * 4) @(negedge clk);
    busRead(3'd0, r);
    chk(r[10] == 1'b1, "R2", "busy while running", r[10], 1);
    repeat (h * (16 * n + 2) + 2) @(negedge clk);
    busRead(3'd0, r);
    chk(r[10] == 1'b0, "R2", "busy after frame", r[10], 0);
    mActive = 0;
    chk(bitCnt - base == 8 * n, "R3", "sclk rising edges", bitCnt - base, 8 * n);
    for (int k = 0; k < n; k++) begin
      logic [7:0] got, exp;
      for (int b = 0; b < 8; b++) got[7 - b] = mosiBits[base + 8 * k + b];
      exp = (k < tx.size()) ? tx[k] : 8'h00;
      chk(got == exp, "R4", "mosi byte", got, exp);
    end
    busRead(3'd3, r);
    chk(r[6:0] == 7'(n), "R5", "rx level", r[6:0], n);
    for (int k = 0; k < n; k++) begin
      busRead(3'd5, r);
      chk(r[7:0] == pat(sd, k), "R6", "rx byte msb first", r[7:0], pat(sd, k));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    byte unsigned q[$];
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1
    busRead(3'd0, r); chk(r == 0, "R1", "ctrl after reset", r, 0);
    busRead(3'd1, r); chk(r == 0, "R1", "total after reset", r, 0);
    busRead(3'd3, r); chk(r == 0, "R1", "status after reset", r, 0);
    chk(spiCsN == 1 && spiSclk == 0, "R1", "pins after reset", {spiCsN, spiSclk}, 2'b10);

    q = '{8'h03, 8'h12, 8'h34, 8'h56};
    runBurst(10, q, 0, 8'h5A);
    q = '{8'hC3, 8'h81};
    runBurst(5, q, 1, 8'hE1);
    q = '{};
    runBurst(3, q, 0, 8'h0F);
    q = '{8'h9B};
    runBurst(1, q, 1, 8'h33);

    // R2: enable clear, no frame
    busWrite(3'd1, 4);
    busWrite(3'd0, 32'h402);
    repeat (20) @(negedge clk);
    busRead(3'd0, r);
    chk(r[10] == 0, "R2", "no start without enable", r[10], 0);
    chk(spiCsN == 1, "R2", "cs stays high", spiCsN, 1);

    // R9 overflow, R10 tx clear
    for (int i = 0; i < 65; i++) busWrite(3'd4, i);
    busRead(3'd3, r);
    chk(r[14:8] == 7'd64, "R9", "tx level full", r[14:8], 64);
    chk(r[16] == 1, "R9", "overflow flag", r[16], 1);
    busWrite(3'd0, 32'h100);
    busRead(3'd3, r);
    chk(r[14:8] == 0 && r[16] == 0, "R10", "tx clear", r, 0);

    // R10 rx clear, R9 empty read
    q = '{};
    seed = 8'h44;
    busWrite(3'd4, 8'h77);
    busWrite(3'd1, 2);
    busWrite(3'd2, 1);
    base = bitCnt;
    @(negedge clk);
    mStart = cyc + 1; mHalf = 2; mN = 2; mActive = 1;
    busWr = 1; busAddr = 3'd0; busWdata = 32'h403;
    @(posedge clk); #1 busWr = 0;
    repeat (2 * 34 + 4) @(negedge clk);
    mActive = 0;
    busRead(3'd3, r);
    chk(r[6:0] == 2, "R5", "rx level before clear", r[6:0], 2);
    busWrite(3'd0, 32'h200);
    busRead(3'd3, r);
    chk(r[6:0] == 0, "R10", "rx clear", r[6:0], 0);
    busRead(3'd5, r);
    chk(r == 0, "R9", "empty rx read", r, 0);

    // R11 soft reset
    busWrite(3'd1, 9);
    busWrite(3'd4, 8'h11);
    busWrite(3'd0, 32'h0000_0007);
    busWrite(3'd0, 32'h8000_0000);
    busRead(3'd0, r);
    chk(r[31] == 1, "R11", "soft reset visible", r[31], 1);
    busRead(3'd0, r);
    chk(r == 0, "R11", "soft reset cleared ctrl", r, 0);
    busRead(3'd1, r);
    chk(r == 0, "R11", "total cleared", r, 0);
    busRead(3'd3, r);
    chk(r == 0, "R11", "status cleared", r, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule